// File: doc/BRIEF.md
# Address Hash CRC Capture

This block watches a received byte stream, one byte per cycle when the byte strobe is high, and runs a CRC-32 over the leading bytes of each frame. A one-cycle frame-start pulse restarts a byte counter and reloads the CRC register. The first six bytes of a frame are the destination address and the next six are the source address. When the sixth byte is absorbed, the running CRC is copied into a destination hash register. When the twelfth byte is absorbed, the running CRC is copied into a source hash register. Because the CRC is not reloaded between the two fields, the source hash covers all twelve address bytes.

After the twelfth byte the calculator freezes. Both hash registers then hold their values until the next capture. Each hash has a valid flag. A frame start clears the flag, and the matching capture sets it. A frame that ends early leaves the register that was not reached holding its old contents, with its flag left cleared. Downstream logic uses the two hashes to index address tables. That lookup is outside this block.

Top module: `addr_hash_crc`

## Requirements
- R1: After reset, both hash outputs are zero and both valid flags are low.
- R2: The CRC is the reflected CRC-32 with polynomial constant 0xEDB88320. The register starts at 0xFFFFFFFF, and each byte is folded in least significant bit first. A stored hash is the register value right after the byte, with no final inversion.
- R3: A frame-start pulse restarts the byte count and reloads the CRC at any time, even in the middle of a frame. If the byte strobe is high in the same cycle, that byte is byte 1 of the new frame.
- R4: In the cycle after byte 6 of a frame is accepted, `dst_hash` equals the CRC over bytes 1 to 6 and `dst_hash_vld` is high.
- R5: In the cycle after byte 12 of a frame is accepted, `src_hash` equals the CRC over bytes 1 to 12 and `src_hash_vld` is high. The source flag never rises while the destination flag is low.
- R6: After byte 12, further bytes are ignored until the next frame start. Neither hash output nor any valid flag changes.
- R7: A frame start clears both valid flags in the next cycle and leaves both hash values unchanged.
- R8: If a frame ends before byte 12, `src_hash` keeps its earlier value and `src_hash_vld` stays low.
- R9: A cycle with the byte strobe low neither counts a byte nor changes the CRC. Gaps inside the address fields do not change the hashes.
- R10: After reset and before the first frame start, bytes are ignored and both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle pulse that begins a new frame |
| byte_en | input | 1 | High when `byte_in` carries a frame byte |
| byte_in | input | 8 | Received byte |
| dst_hash | output | 32 | CRC captured at the end of the destination address |
| dst_hash_vld | output | 1 | `dst_hash` belongs to the current frame |
| src_hash | output | 32 | CRC captured at the end of the source address |
| src_hash_vld | output | 1 | `src_hash` belongs to the current frame |

## Verification
The assertions assume that `frm_start` is a single-cycle pulse, that frame bytes arrive only while `byte_en` is high, and that after reset the first meaningful byte comes with or after a frame start. The stimulus drives every input on the falling clock edge. It raises the frame start only on the first byte of a frame, or as a lone restart pulse. It inserts idle cycles inside the address fields, sends bytes before any frame start and past the twelfth byte, and cuts frames short, so that the freeze, hold and clear rules all get exercised.

// File: rtl/ahc_pkg.sv
package ahc_pkg;
  localparam int unsigned     CRC_W      = 32;
  localparam logic [31:0]     CRC32_POLY = 32'hEDB88320;
  localparam logic [31:0]     CRC32_INIT = 32'hFFFFFFFF;
  localparam int unsigned     ADDR_BYTES = 6;

  typedef struct packed {
    logic dst;
    logic src;
  } ahc_cap_t;
endpackage

// File: rtl/ahc_ctrl.sv
module ahc_ctrl
  import ahc_pkg::*;
#(
  parameter int unsigned DA_BYTES = 6,
  parameter int unsigned SA_BYTES = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sof_i,
  input  logic     vld_i,
  output logic     accept_o,
  output ahc_cap_t cap_o,
  output logic     done_o
);
  localparam int unsigned TOTAL = DA_BYTES + SA_BYTES;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_DA = CNT_W'(DA_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_SA = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TOTAL);

  logic [CNT_W-1:0] cnt_q, base, cnt_d;

  // Counter sits at CNT_END when idle or frozen; a frame start rebases it.
  always_comb begin
    base     = sof_i ? '0 : cnt_q;
    accept_o = vld_i && (base < CNT_END);
    cnt_d    = accept_o ? base + 1'b1 : base;
    cap_o.dst = accept_o && (base == LAST_DA);
    cap_o.src = accept_o && (base == LAST_SA);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_END;
    else     cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == CNT_END);

  p_cnt_limit_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_END);
  p_one_capture_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cap_o.dst, cap_o.src}));
  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !sof_i) |-> !accept_o);
endmodule

// File: rtl/ahc_crc.sv
module ahc_crc #(
  parameter int unsigned      CRC_W  = 32,
  parameter int unsigned      DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 32'hEDB88320,
  parameter logic [CRC_W-1:0] INIT   = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign seed     = restart_i ? INIT : crc_q;
  assign stage[0] = seed;

  // One shift-and-reduce step per data bit, least significant bit first.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ data_i[b];
    assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_next_o = accept_i ? stage[DATA_W] : seed;

  always_ff @(posedge clk) begin
    if (rst) crc_q <= INIT;
    else     crc_q <= crc_next_o;
  end

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && !accept_i) |=> $stable(crc_q));
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (restart_i && !accept_i) |=> (crc_q == INIT));
endmodule

// File: rtl/ahc_capture.sv
module ahc_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o,
  output logic         vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= '0;
      vld_o <= 1'b0;
    end else begin
      if (load_i) val_o <= val_i;
      if (load_i)       vld_o <= 1'b1;
      else if (clear_i) vld_o <= 1'b0;
    end
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> !vld_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(val_o));
endmodule

// File: rtl/addr_hash_crc.sv
module addr_hash_crc
  import ahc_pkg::*;
#(
  parameter int unsigned DA_BYTES = ADDR_BYTES,
  parameter int unsigned SA_BYTES = ADDR_BYTES,
  parameter int unsigned HASH_W   = CRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              byte_en,
  input  logic [7:0]        byte_in,
  output logic [HASH_W-1:0] dst_hash,
  output logic              dst_hash_vld,
  output logic [HASH_W-1:0] src_hash,
  output logic              src_hash_vld
);
  localparam int unsigned N_CAP = 2;

  logic             accept, done;
  ahc_cap_t         cap;
  logic [HASH_W-1:0] crc_next;
  logic [N_CAP-1:0] load_v, vld_v;
  logic [HASH_W-1:0] hash_v [N_CAP];

  ahc_ctrl #(.DA_BYTES(DA_BYTES), .SA_BYTES(SA_BYTES)) i_ctrl (
    .clk(clk), .rst(rst), .sof_i(frm_start), .vld_i(byte_en),
    .accept_o(accept), .cap_o(cap), .done_o(done)
  );

  ahc_crc #(.CRC_W(HASH_W), .DATA_W(8),
            .POLY(HASH_W'(CRC32_POLY)), .INIT(HASH_W'(CRC32_INIT))) i_crc (
    .clk(clk), .rst(rst), .restart_i(frm_start), .accept_i(accept),
    .data_i(byte_in), .crc_next_o(crc_next)
  );

  assign load_v = {cap.src, cap.dst};

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    ahc_capture #(.W(HASH_W)) i_cap (
      .clk(clk), .rst(rst), .clear_i(frm_start), .load_i(load_v[g]),
      .val_i(crc_next), .val_o(hash_v[g]), .vld_o(vld_v[g])
    );
  end

  assign dst_hash     = hash_v[0];
  assign dst_hash_vld = vld_v[0];
  assign src_hash     = hash_v[1];
  assign src_hash_vld = vld_v[1];

  p_src_after_dst_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(src_hash_vld) |-> dst_hash_vld);
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !frm_start) |=> ($stable(dst_hash) && $stable(src_hash)
                              && $stable(dst_hash_vld) && $stable(src_hash_vld)));
endmodule

// File: tb/test_addr_hash_crc.sv
module test_addr_hash_crc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start = 1'b0;
  logic        byte_en = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [31:0] dst_hash, src_hash;
  logic        dst_hash_vld, src_hash_vld;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  addr_hash_crc i_addr_hash_crc (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_en(byte_en),
    .byte_in(byte_in), .dst_hash(dst_hash), .dst_hash_vld(dst_hash_vld),
    .src_hash(src_hash), .src_hash_vld(src_hash_vld)
  );

  // bit 96: insert idle gaps; bits [8k+7:8k]: byte k+1
  localparam logic [96:0] VEC [4] = '{
    {1'b0, 96'h0123456789ABCDEF00112233},
    {1'b1, 96'hFFFFFFFFFFFF0A0B0C0D0E0F},
    {1'b0, 96'h000000000000000000000000},
    {1'b1, 96'h5A5AA5A5C3C33C3C96966969}
  };

  function automatic logic [31:0] crc_of(input logic [95:0] v, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, v[8*k +: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic put(input logic s, input logic v, input logic [7:0] d);
    @(negedge clk);
    frm_start = s; byte_en = v; byte_in = d;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 8'h00);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] old_src;
    logic [95:0] nb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    chk("R1 dst_hash", dst_hash, 32'h0);
    chk("R1 src_hash", src_hash, 32'h0);
    chk("R1 flags", {30'h0, dst_hash_vld, src_hash_vld}, 32'h0);

    // R10 bytes before any frame start are ignored
    for (int k = 0; k < 14; k++) put(1'b0, 1'b1, 8'(k * 17 + 3));
    idle();
    chk("R10 flags", {30'h0, dst_hash_vld, src_hash_vld}, 32'h0);
    chk("R10 dst_hash", dst_hash, 32'h0);

    // Table-driven frames: R2 R4 R5 R6 R9
    foreach (VEC[i]) begin
      for (int k = 0; k < 12; k++) begin
        put(k == 0, 1'b1, VEC[i][8*k +: 8]);
        if (VEC[i][96] && (k == 2 || k == 8)) begin idle(); idle(); end // R9 gaps
        if (k == 5) begin
          idle();
          chk("R4 dst_hash", dst_hash, crc_of(VEC[i][95:0], 6));
          chk("R4 dst_hash_vld", {31'h0, dst_hash_vld}, 32'h1);
          chk("R5 src_hash_vld low before byte 12", {31'h0, src_hash_vld}, 32'h0);
        end
      end
      idle();
      chk("R2 R5 src_hash", src_hash, crc_of(VEC[i][95:0], 12));
      chk("R5 src_hash_vld", {31'h0, src_hash_vld}, 32'h1);
      for (int k = 0; k < 5; k++) put(1'b0, 1'b1, 8'hC0 + 8'(k));
      idle();
      chk("R6 dst_hash frozen", dst_hash, crc_of(VEC[i][95:0], 6));
      chk("R6 src_hash frozen", src_hash, crc_of(VEC[i][95:0], 12));
      chk("R6 flags frozen", {30'h0, dst_hash_vld, src_hash_vld}, 32'h3);
    end

    // R7 lone frame start clears flags, keeps values
    old_src = src_hash;
    put(1'b1, 1'b0, 8'h00);
    idle();
    chk("R7 flags cleared", {30'h0, dst_hash_vld, src_hash_vld}, 32'h0);
    chk("R7 dst_hash kept", dst_hash, crc_of(VEC[3][95:0], 6));
    chk("R7 src_hash kept", src_hash, old_src);

    // R8 short frame of 8 bytes
    nb = 96'h111213141516171819202122;
    for (int k = 0; k < 8; k++) put(k == 0, 1'b1, nb[8*k +: 8]);
    repeat (4) idle();
    chk("R8 dst_hash new", dst_hash, crc_of(nb, 6));
    chk("R8 src_hash kept", src_hash, old_src);
    chk("R8 src_hash_vld low", {31'h0, src_hash_vld}, 32'h0);

    // R3 restart in the middle of a frame
    for (int k = 0; k < 4; k++) put(k == 0, 1'b1, 8'hE0 + 8'(k));
    nb = 96'hDEADBEEF0BADF00D13572468;
    for (int k = 0; k < 12; k++) put(k == 0, 1'b1, nb[8*k +: 8]);
    idle();
    chk("R3 dst_hash after restart", dst_hash, crc_of(nb, 6));
    chk("R3 src_hash after restart", src_hash, crc_of(nb, 12));
    chk("R3 flags", {30'h0, dst_hash_vld, src_hash_vld}, 32'h3);

    repeat (2) idle();
    finish_run();
  end
endmodule